// File: doc/BRIEF.md
# Per-Input Request Generator for an Iterative Crossbar Scheduler

This block sits at one input port of a crossbar scheduler that matches inputs to outputs by repeated rounds of request, grant and accept. Each scheduling slot opens with a slot strobe. After that, each round ends with an iteration strobe, up to a fixed number of rounds per slot. While the input is still free, the block presents one request line per output, raised for each output whose per-output queue at this input holds data. Rounds overlap: the requests for the next round are already driven while the accept arbiter settles the current one. A grant that reaches this input's accept arbiter therefore silences the requests only from the following round onward.

Connections can also carry over from one slot to the next. At the slot strobe, the decision logic supplies a keep vector that names the output to stay connected to. If that output's queue still holds data, the connection is held for the slot. While it is held, the grant arbiter at that output and this input's accept arbiter are both disabled, and no requests go out. If the held queue runs dry during the slot, the hold is released for the rest of the slot and the input competes normally.

Top module: `voq_req_gen`

## Requirements
- R1: While this input is free (no hold in force and no grant taken this slot) and the slot's round window is open, `req[j]` equals `voq_ne[j]` in the same cycle. Otherwise every bit of `req` is 0.
- R2: During reset and after it, `req`, `grant_dis` and `accept_dis` are all 0 until the first `slot_start`, whatever `voq_ne` and `iter_strobe` do.
- R3: A `slot_start` sampled at a clock edge opens a new round window, clears any grant taken and reloads the hold state. From the next cycle, an input with no hold requests exactly its non-empty queues.
- R4: When `iter_strobe` and `any_grant` are both high at an edge inside an open window, `req` is 0 from the next cycle until the next `slot_start`.
- R5: A slot allows `N_ITER` rounds (default 3). After the `N_ITER`-th `iter_strobe`, `req` is 0 until the next `slot_start`, and further `iter_strobe` pulses have no effect.
- R6: At a `slot_start` edge, output j becomes held when `keep_conn[j]` and `voq_ne[j]` are both 1. While it is held, `grant_dis[j]` is 1, `accept_dis` is 1 and `req` is 0.
- R7: When the queue of a held output reads empty, the hold ends in that same cycle (`grant_dis[j]` and `accept_dis` go to 0). It stays released for the rest of the slot even if the queue refills, and the input then requests under R1.
- R8: When `slot_start` and `iter_strobe` are high in the same cycle, the slot strobe wins: neither the round count nor `any_grant` is taken from that cycle.
- R9: A `keep_conn` bit that points at an empty queue at the `slot_start` edge creates no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| voq_ne | input | N_OUT | Per-output queue non-empty flags at this input |
| keep_conn | input | N_OUT | Connection to keep into the new slot (at most one bit set) |
| any_grant | input | 1 | Accept arbiter saw at least one grant in the current round |
| iter_strobe | input | 1 | End of a request-grant-accept round |
| slot_start | input | 1 | Start of a new scheduling slot |
| req | output | N_OUT | Request lines to the grant arbiters |
| grant_dis | output | N_OUT | Disable for the grant arbiter of a held output |
| accept_dis | output | 1 | Disable for this input's accept arbiter |

## Verification
The assertions assume that `keep_conn` has at most one bit set, because the decision logic keeps no more than one connection per input. The stimulus meets this by drawing either zero or a single bit for `keep_conn`. Queue flags change only rarely in the random stream, so that held connections last across several rounds before a queue runs dry. Strobes and `any_grant` are drawn freely, which means slot and round strobes sometimes coincide, and rounds are sometimes strobed after the window has closed.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef struct packed {
    logic slot;
    logic iter;
    logic grant;
  } rg_strobe_t;
endpackage

// File: rtl/rg_iter_track.sv
module rg_iter_track #(
  parameter int N_ITER = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rg_pkg::rg_strobe_t stb,
  output logic              window_open,
  output logic              granted
);
  localparam int CW = $clog2(N_ITER + 1);
  localparam logic [CW-1:0] LAST = CW'(N_ITER);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          gr_q, gr_d;
  logic          en;

  assign window_open = (cnt_q < LAST);
  assign granted     = gr_q;

  always_comb begin
    cnt_d = cnt_q;
    gr_d  = gr_q;
    en    = 1'b0;
    if (stb.slot) begin
      cnt_d = '0;
      gr_d  = 1'b0;
      en    = 1'b1;
    end else if (stb.iter && window_open) begin
      cnt_d = cnt_q + 1'b1;
      gr_d  = gr_q | stb.grant;
      en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LAST;
      gr_q  <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      gr_q  <= gr_d;
    end
  end

  // R5: the round count never passes the per-slot limit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4: a grant taken inside an open window marks the input as matched
  a_r4_grant_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.iter && stb.grant && !stb.slot && window_open) |=> granted);

  // R8: a slot strobe always reopens the window with no grant pending
  a_r8_slot_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stb.slot |=> (window_open && !granted));
endmodule

// File: rtl/rg_hold_track.sv
module rg_hold_track #(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start,
  input  logic [N_OUT-1:0] voq_ne,
  input  logic [N_OUT-1:0] keep_conn,
  output logic [N_OUT-1:0] hold_eff
);
  logic [N_OUT-1:0] held_q, held_d;

  always_comb begin
    if (slot_start) held_d = keep_conn & voq_ne;
    else            held_d = held_q & voq_ne;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign hold_eff = held_q & voq_ne;

  // R7: once a held queue reads empty, that hold does not come back within the slot
  a_r7_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_start && ((held_q & ~voq_ne) != '0)) |=> ((held_q & $past(held_q & ~voq_ne)) == '0));

  // R9: no hold can start on an empty queue
  a_r9_no_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> ((held_q & ~$past(voq_ne)) == '0));
endmodule

// File: rtl/rg_req_mask.sv
module rg_req_mask #(
  parameter int N_OUT = 4
) (
  input  logic [N_OUT-1:0] voq_ne,
  input  logic [N_OUT-1:0] hold_eff,
  input  logic             window_open,
  input  logic             granted,
  output logic [N_OUT-1:0] req,
  output logic [N_OUT-1:0] grant_dis,
  output logic             accept_dis
);
  logic busy;

  always_comb begin
    busy       = granted | (|hold_eff);
    req        = (window_open && !busy) ? voq_ne : '0;
    grant_dis  = hold_eff;
    accept_dis = |hold_eff;
  end
endmodule

// File: rtl/voq_req_gen.sv
module voq_req_gen #(
  parameter int N_OUT  = 4,
  parameter int N_ITER = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] voq_ne,
  input  logic [N_OUT-1:0] keep_conn,
  input  logic             any_grant,
  input  logic             iter_strobe,
  input  logic             slot_start,
  output logic [N_OUT-1:0] req,
  output logic [N_OUT-1:0] grant_dis,
  output logic             accept_dis
);
  rg_pkg::rg_strobe_t stb;
  logic               window_open;
  logic               granted;
  logic [N_OUT-1:0]   hold_eff;

  assign stb = '{slot: slot_start, iter: iter_strobe, grant: any_grant};

  rg_iter_track #(.N_ITER(N_ITER)) u_iter (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .window_open(window_open), .granted(granted)
  );

  rg_hold_track #(.N_OUT(N_OUT)) u_hold (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .voq_ne(voq_ne), .keep_conn(keep_conn), .hold_eff(hold_eff)
  );

  rg_req_mask #(.N_OUT(N_OUT)) u_mask (
    .voq_ne(voq_ne), .hold_eff(hold_eff), .window_open(window_open),
    .granted(granted), .req(req), .grant_dis(grant_dis),
    .accept_dis(accept_dis)
  );

  // R1: requests only ever go to outputs whose queues hold data
  a_r1_req_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (req & ~voq_ne) == '0);

  // R6: a held connection blocks every request from this input
  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    accept_dis |-> (req == '0));

  // R6: at most one output is held (keep vector is one-hot or zero)
  a_r6_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_dis));

  // R3: after a slot strobe the input either holds or requests its whole queue set
  a_r3_slot_opens: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> (accept_dis || (req == voq_ne)));
endmodule

// File: tb/test_voq_req_gen.sv
module test_voq_req_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int NI = 3;
  localparam int WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] voq_ne, keep_conn;
  logic         any_grant, iter_strobe, slot_start;
  logic [N-1:0] req, grant_dis;
  logic         accept_dis;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int           m_cnt;
  bit           m_gr;
  logic [N-1:0] m_held;

  always #(CLK_PERIOD/2) clk = ~clk;

  voq_req_gen #(.N_OUT(N), .N_ITER(NI)) i_voq_req_gen (
    .clk(clk), .rst_n(rst_n), .voq_ne(voq_ne), .keep_conn(keep_conn),
    .any_grant(any_grant), .iter_strobe(iter_strobe), .slot_start(slot_start),
    .req(req), .grant_dis(grant_dis), .accept_dis(accept_dis)
  );

  function automatic logic [N-1:0] exp_hold();
    return m_held & voq_ne;
  endfunction

  function automatic logic [N-1:0] exp_req();
    logic [N-1:0] h = exp_hold();
    if (m_cnt < NI && !m_gr && h == '0) return voq_ne;
    return '0;
  endfunction

  function automatic string auto_tag();
    if (exp_hold() != '0) return "R6";
    if (m_cnt >= NI)      return "R5";
    if (m_gr)             return "R4";
    return "R1";
  endfunction

  task automatic chk(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] v, input logic [N-1:0] k,
                      input logic ss, input logic is, input logic ag, input string tag);
    string t;
    @(negedge clk);
    voq_ne = v; keep_conn = k; slot_start = ss; iter_strobe = is; any_grant = ag;
    #1;
    t = (tag == "") ? auto_tag() : tag;
    chk(t, "req", req, exp_req());
    chk((tag == "") ? "R6" : tag, "grant_dis", grant_dis, exp_hold());
    chk((tag == "") ? "R6" : tag, "accept_dis", {{(N-1){1'b0}}, accept_dis},
        {{(N-1){1'b0}}, (exp_hold() != '0)});
    if (ss) begin
      m_cnt = 0; m_gr = 0; m_held = k & v;
    end else begin
      if (is && m_cnt < NI) begin
        m_cnt++;
        m_gr = m_gr | ag;
      end
      m_held = m_held & v;
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] k;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    voq_ne = 4'b1011; keep_conn = '0; slot_start = 0; iter_strobe = 0; any_grant = 0;
    m_cnt = NI; m_gr = 0; m_held = '0;
    #(CLK_PERIOD*2 + 1);
    chk("R2", "req in reset", req, '0);
    chk("R2", "grant_dis in reset", grant_dis, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: no requests before the first slot, even with strobes
    step(4'b1111, 4'b0000, 0, 1, 0, "R2");
    step(4'b0110, 4'b0100, 0, 0, 0, "R2");
    // R3: first slot opens window
    step(4'b0110, 4'b0000, 1, 0, 0, "R3");
    step(4'b0110, 4'b0000, 0, 0, 0, "R3");
    step(4'b1001, 4'b0000, 0, 1, 0, "R1");
    // R4: grant at a round boundary silences later rounds
    step(4'b1001, 4'b0000, 0, 1, 1, "R4");
    step(4'b1111, 4'b0000, 0, 0, 0, "R4");
    step(4'b1111, 4'b0000, 0, 1, 0, "R4");
    // R5: three rounds close the window
    step(4'b0101, 4'b0000, 1, 0, 0, "R3");
    step(4'b0101, 4'b0000, 0, 1, 0, "R5");
    step(4'b0101, 4'b0000, 0, 1, 0, "R5");
    step(4'b0101, 4'b0000, 0, 1, 0, "R5");
    step(4'b0101, 4'b0000, 0, 0, 0, "R5");
    step(4'b0101, 4'b0000, 0, 1, 1, "R5");
    // R6: held connection
    step(4'b1111, 4'b0010, 1, 0, 0, "R6");
    step(4'b1111, 4'b0000, 0, 0, 0, "R6");
    step(4'b1111, 4'b0000, 0, 1, 0, "R6");
    // R7: queue drains, hold released, stays released after refill
    step(4'b1101, 4'b0000, 0, 0, 0, "R7");
    step(4'b1111, 4'b0000, 0, 0, 0, "R7");
    step(4'b1111, 4'b0000, 0, 1, 0, "R7");
    // R8: slot and round strobes together
    step(4'b0011, 4'b0000, 1, 1, 1, "R8");
    step(4'b0011, 4'b0000, 0, 0, 0, "R8");
    step(4'b0011, 4'b0000, 0, 1, 0, "R8");
    step(4'b0011, 4'b0000, 0, 1, 0, "R8");
    step(4'b0011, 4'b0000, 0, 0, 0, "R8");
    // R9: keep pointing at an empty queue
    step(4'b0111, 4'b1000, 1, 0, 0, "R9");
    step(4'b0111, 4'b0000, 0, 0, 0, "R9");
    // random
    v = 4'b1010;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 5) == 0) v = N'($urandom);
      k = ($urandom_range(0, 1) == 1) ? (N'(1) << $urandom_range(0, N-1)) : '0;
      step(v, k, ($urandom_range(0, 7) == 0), ($urandom_range(0, 1) == 1),
           ($urandom_range(0, 2) == 0), "");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule